// File: doc/BRIEF.md
# Predicated Vector Writeback Merge

This block forms the final value written into a 512-bit vector register after a vector operation. It takes the freshly computed result, the previous destination contents and a predicate, and decides byte by byte whether each destination byte receives the new result, keeps its old value, or is cleared. The predicate comes from a mask register picked by a 3-bit selector. Selector value 0 is a special code that means "no predicate": every element is written.

Each mask bit governs one element. The element size is 8, 16, 32 or 64 bits, so one mask bit covers 1, 2, 4 or 8 bytes. The active vector length of 128, 256 or 512 bits limits how many mask bits take part. A per-operation flag chooses between clearing unselected elements (zeroing) and preserving them (merging). Bytes above the active length are always cleared. The merged vector is captured in an output register, and an output valid flag marks it one cycle after the input valid.

Top module: `vmask_writeback`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises with no input valid, `out_valid` is 0 and `out_vec` is all zeros.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is 0, `out_vec` holds its previous value on the next clock.
- R3: When `mask_sel` is 0, every element inside the active length takes its value from `new_vec`. The contents of `mask_val` have no effect.
- R4: When `mask_sel` is 1 to 7, element i is selected exactly when bit i of `mask_val` is 1. Element 0 occupies the lowest bytes.
- R5: `elem_size` encodes the element width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits and 3 is 64 bits. Element i covers bytes i*W/8 to (i+1)*W/8-1. The same mask applied at 32-bit and at 64-bit width differs only in this byte mapping.
- R6: When `zero_mode` is 1, each byte of an unselected element inside the active length is output as 0.
- R7: When `zero_mode` is 0, each byte of an unselected element inside the active length takes the matching byte of `old_vec`.
- R8: `vec_len` encodes the active length: 0 is 128 bits, 1 is 256 bits, and 2 or 3 is 512 bits. Bytes at or above the active length are output as 0 in both modes.
- R9: Only mask bits below (active length / element width) take effect. Higher bits of `mask_val` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input operands are valid this cycle |
| new_vec | input | 512 | Freshly computed result vector |
| old_vec | input | 512 | Previous destination contents |
| mask_sel | input | 3 | Predicate selector; 0 means unmasked |
| mask_val | input | 64 | Contents of the selected mask register |
| elem_size | input | 2 | Element width code (see R5) |
| vec_len | input | 2 | Active vector length code (see R8) |
| zero_mode | input | 1 | 1 = clear unselected elements, 0 = keep old value |
| out_valid | output | 1 | `out_vec` holds a new result |
| out_vec | output | 512 | Merged vector for register writeback |

## Verification
A wrong element-to-byte mapping or a stale length limit shows up in `out_vec` in the very cycle after the offending operation is accepted. It appears as one or more bytes that hold new, old or zero data where another source was due. Because the datapath holds no state beyond the output register, any error is visible after a single operation and does not need a sequence to build up. A stuck valid register shows as `out_valid` failing to follow `in_valid` by exactly one clock. A register that reloads on idle cycles shows as `out_vec` changing while `in_valid` is low.

// File: rtl/vmw_pkg.sv
// Package: shared encodings and helpers for the predicated writeback merge.
// Assumes the vector width is a multiple of 32 bytes so that the quarter
// and half lengths are whole bytes.
package vmw_pkg;

    // Element width codes; the value is log2 of the bytes per element.
    typedef enum logic [1:0] {
        ESZ_B8  = 2'd0,
        ESZ_B16 = 2'd1,
        ESZ_B32 = 2'd2,
        ESZ_B64 = 2'd3
    } esz_e;

    // Active vector length codes; the last two both mean full width.
    typedef enum logic [1:0] {
        VL_QUARTER = 2'd0,
        VL_HALF    = 2'd1,
        VL_FULL    = 2'd2,
        VL_FULL_B  = 2'd3
    } vlen_e;

    // Number of live bytes for a length code, given the full byte count.
    function automatic int unsigned live_bytes(input logic [1:0] vl,
                                               input int unsigned full);
        case (vl)
            VL_QUARTER: return full / 4;
            VL_HALF:    return full / 2;
            default:    return full;
        endcase
    endfunction

endpackage

// File: rtl/vmw_mask_select.sv
// Module: vmw_mask_select
// Builds the effective per-element predicate. Selector 0 gives an all-ones
// mask; any other selector uses the supplied register contents. Bits at or
// above (live bytes >> element-size code) are cleared.
// Assumes MASK_BITS equals the number of bytes in a full vector.
module vmw_mask_select #(
    parameter int MASK_BITS = 64,
    parameter int SEL_BITS  = 3
) (
    input  logic [SEL_BITS-1:0]  mask_sel,
    input  logic [MASK_BITS-1:0] mask_val,
    input  logic [1:0]           elem_size,
    input  logic [1:0]           vec_len,
    output logic [MASK_BITS-1:0] mask_used
);
    import vmw_pkg::*;

    localparam int CNT_W = $clog2(MASK_BITS + 1);

    logic [CNT_W-1:0]     live_cnt;
    logic [CNT_W-1:0]     elem_cnt;
    logic [MASK_BITS-1:0] raw_mask;

    // Purpose: count how many mask bits the current length and size use.
    always_comb begin
        live_cnt = CNT_W'(live_bytes(vec_len, MASK_BITS));
        elem_cnt = live_cnt >> elem_size;
    end

    // Purpose: selector 0 stands for "no predicate".
    always_comb begin
        raw_mask = (mask_sel == '0) ? '1 : mask_val;
    end

    // Purpose: clear mask bits whose element lies beyond the active length.
    for (genvar i = 0; i < MASK_BITS; i++) begin : g_trim
        assign mask_used[i] = raw_mask[i] && (CNT_W'(i) < elem_cnt);
    end

endmodule

// File: rtl/vmw_byte_expand.sv
// Module: vmw_byte_expand
// Turns the per-element predicate into per-byte enables according to the
// element width, and flags which bytes lie inside the active length.
// Assumes mask_used has already been trimmed to the live element count.
module vmw_byte_expand #(
    parameter int BYTES = 64
) (
    input  logic [BYTES-1:0] mask_used,
    input  logic [1:0]       elem_size,
    input  logic [1:0]       vec_len,
    output logic [BYTES-1:0] byte_en,
    output logic [BYTES-1:0] byte_live
);
    import vmw_pkg::*;

    localparam int CNT_W = $clog2(BYTES + 1);

    logic [CNT_W-1:0] live_cnt;

    // Purpose: number of bytes inside the active vector length.
    always_comb begin
        live_cnt = CNT_W'(live_bytes(vec_len, BYTES));
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        localparam int IDX1 = b;
        localparam int IDX2 = b / 2;
        localparam int IDX4 = b / 4;
        localparam int IDX8 = b / 8;

        // Purpose: pick the mask bit owning this byte for the element width.
        always_comb begin
            case (esz_e'(elem_size))
                ESZ_B8:  byte_en[b] = mask_used[IDX1];
                ESZ_B16: byte_en[b] = mask_used[IDX2];
                ESZ_B32: byte_en[b] = mask_used[IDX4];
                default: byte_en[b] = mask_used[IDX8];
            endcase
        end

        assign byte_live[b] = (CNT_W'(b) < live_cnt);
    end

endmodule

// File: rtl/vmw_lane_merge.sv
// Module: vmw_lane_merge
// Per-byte three-way choice: new data, old data or zero. Bytes outside the
// active length are zero; unselected live bytes follow the zeroing flag.
// Assumes byte_en is already 0 for bytes outside the active length.
module vmw_lane_merge #(
    parameter int BYTES = 64
) (
    input  logic [BYTES*8-1:0] new_vec,
    input  logic [BYTES*8-1:0] old_vec,
    input  logic [BYTES-1:0]   byte_en,
    input  logic [BYTES-1:0]   byte_live,
    input  logic               zero_mode,
    output logic [BYTES*8-1:0] merged
);

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        // Purpose: choose the source for one destination byte.
        always_comb begin
            if (!byte_live[b]) begin
                merged[b*8 +: 8] = 8'h00;
            end else if (byte_en[b]) begin
                merged[b*8 +: 8] = new_vec[b*8 +: 8];
            end else if (zero_mode) begin
                merged[b*8 +: 8] = 8'h00;
            end else begin
                merged[b*8 +: 8] = old_vec[b*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/vmask_writeback.sv
// Module: vmask_writeback (top)
// Predicated writeback merge: trims and expands the mask, merges byte
// lanes and registers the result with a one-cycle valid flag.
// Assumes the mask register contents are presented in the same cycle as
// in_valid; synchronous active-low reset.
module vmask_writeback #(
    parameter int VEC_BITS = 512,
    parameter int SEL_BITS = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [VEC_BITS-1:0]   new_vec,
    input  logic [VEC_BITS-1:0]   old_vec,
    input  logic [SEL_BITS-1:0]   mask_sel,
    input  logic [VEC_BITS/8-1:0] mask_val,
    input  logic [1:0]            elem_size,
    input  logic [1:0]            vec_len,
    input  logic                  zero_mode,
    output logic                  out_valid,
    output logic [VEC_BITS-1:0]   out_vec
);

    localparam int BYTES = VEC_BITS / 8;

    logic [BYTES-1:0]    mask_used;
    logic [BYTES-1:0]    byte_en;
    logic [BYTES-1:0]    byte_live;
    logic [VEC_BITS-1:0] merged;

    vmw_mask_select #(
        .MASK_BITS (BYTES),
        .SEL_BITS  (SEL_BITS)
    ) u_sel (
        .mask_sel  (mask_sel),
        .mask_val  (mask_val),
        .elem_size (elem_size),
        .vec_len   (vec_len),
        .mask_used (mask_used)
    );

    vmw_byte_expand #(
        .BYTES (BYTES)
    ) u_exp (
        .mask_used (mask_used),
        .elem_size (elem_size),
        .vec_len   (vec_len),
        .byte_en   (byte_en),
        .byte_live (byte_live)
    );

    vmw_lane_merge #(
        .BYTES (BYTES)
    ) u_mrg (
        .new_vec   (new_vec),
        .old_vec   (old_vec),
        .byte_en   (byte_en),
        .byte_live (byte_live),
        .zero_mode (zero_mode),
        .merged    (merged)
    );

    // Purpose: output register; captures the merge only on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec <= merged;
            end
        end
    end

endmodule

// File: rtl/vmw_writeback_chk.sv
// Module: vmw_writeback_chk
// Port-level checker for vmask_writeback, attached with bind below.
module vmw_writeback_chk #(
    parameter int VEC_BITS = 512,
    parameter int SEL_BITS = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [VEC_BITS-1:0]   new_vec,
    input logic [VEC_BITS-1:0]   old_vec,
    input logic [SEL_BITS-1:0]   mask_sel,
    input logic [VEC_BITS/8-1:0] mask_val,
    input logic [1:0]            elem_size,
    input logic [1:0]            vec_len,
    input logic                  zero_mode,
    input logic                  out_valid,
    input logic [VEC_BITS-1:0]   out_vec
);

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_vec));

    assert_unmasked_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mask_sel == '0 && vec_len[1]) |=> out_vec == $past(new_vec));

    assert_zero_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_mode && mask_sel != '0 && mask_val == '0) |=> out_vec == '0);

    assert_merge_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !zero_mode && mask_sel != '0 && mask_val == '0 && vec_len[1])
        |=> out_vec == $past(old_vec));

    assert_tail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_len == 2'd0) |=> out_vec[VEC_BITS-1:VEC_BITS/4] == '0);

endmodule

bind vmask_writeback vmw_writeback_chk #(
    .VEC_BITS (VEC_BITS),
    .SEL_BITS (SEL_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .new_vec   (new_vec),
    .old_vec   (old_vec),
    .mask_sel  (mask_sel),
    .mask_val  (mask_val),
    .elem_size (elem_size),
    .vec_len   (vec_len),
    .zero_mode (zero_mode),
    .out_valid (out_valid),
    .out_vec   (out_vec)
);

// File: tb/sim_vmask_writeback.sv
module sim_vmask_writeback;

    localparam int CLK_PERIOD = 10;
    localparam int VB = 512;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [VB-1:0] new_vec;
    logic [VB-1:0] old_vec;
    logic [2:0]    mask_sel;
    logic [63:0]   mask_val;
    logic [1:0]    elem_size;
    logic [1:0]    vec_len;
    logic          zero_mode;
    logic          out_valid;
    logic [VB-1:0] out_vec;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmask_writeback u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .new_vec(new_vec), .old_vec(old_vec), .mask_sel(mask_sel),
        .mask_val(mask_val), .elem_size(elem_size), .vec_len(vec_len),
        .zero_mode(zero_mode), .out_valid(out_valid), .out_vec(out_vec)
    );

    // Expected merge computed arithmetically from the requirements.
    function automatic logic [VB-1:0] model(input logic [VB-1:0] nv,
                                            input logic [VB-1:0] ov,
                                            input logic [2:0] sel,
                                            input logic [63:0] m,
                                            input logic [1:0] es,
                                            input logic [1:0] vl,
                                            input logic z);
        logic [VB-1:0] r = '0;
        int lb = (vl == 2'd0) ? 16 : (vl == 2'd1) ? 32 : 64;
        int w  = 1 << es;
        int n  = lb / w;
        for (int b = 0; b < 64; b++) begin
            int e = b / w;
            bit on = (sel == 3'd0) || (e < n && m[e]);
            if (b >= lb)      r[b*8 +: 8] = 8'h00;
            else if (on)      r[b*8 +: 8] = nv[b*8 +: 8];
            else if (z)       r[b*8 +: 8] = 8'h00;
            else              r[b*8 +: 8] = ov[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [VB-1:0] rnd_vec();
        logic [VB-1:0] v;
        for (int k = 0; k < VB/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check_vec(input string tag, input logic [VB-1:0] act,
                             input logic [VB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, check it at the next one.
    task automatic run_op(input string tag, input logic [2:0] sel,
                          input logic [63:0] m, input logic [1:0] es,
                          input logic [1:0] vl, input logic z);
        logic [VB-1:0] nv = rnd_vec();
        logic [VB-1:0] ov = rnd_vec();
        in_valid = 1'b1; new_vec = nv; old_vec = ov; mask_sel = sel;
        mask_val = m; elem_size = es; vec_len = vl; zero_mode = z;
        @(posedge clk);
        @(negedge clk);
        check_bit({tag, " R2 valid"}, out_valid, 1'b1);
        check_vec(tag, out_vec, model(nv, ov, sel, m, es, vl, z));
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; new_vec = '0; old_vec = '0;
        mask_sel = '0; mask_val = '0; elem_size = '0; vec_len = '0; zero_mode = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R1 reset valid", out_valid, 1'b0);
        check_vec("R1 reset data", out_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1 post-reset valid", out_valid, 1'b0);
        check_vec("R1 post-reset data", out_vec, '0);

        // Sweep: size, length, mode, selector, several mask patterns (R3-R8).
        for (int es = 0; es < 4; es++)
            for (int vl = 0; vl < 4; vl++)
                for (int z = 0; z < 2; z++)
                    for (int sel = 0; sel < 8; sel++)
                        for (int p = 0; p < 3; p++) begin
                            logic [63:0] m = (p == 0) ? 64'h0 :
                                             (p == 1) ? 64'hAAAA_5555_F0F0_0F0F :
                                             {$urandom, $urandom};
                            run_op("R3 R4 R5 R6 R7 R8 sweep", 3'(sel), m,
                                   2'(es), 2'(vl), z[0]);
                        end

        // R9: mask bits above the used count are ignored (64-bit, full length).
        run_op("R9 high bits ignored", 3'd5, 64'hFFFF_FFFF_FFFF_FF00, 2'd3, 2'd2, 1'b0);
        run_op("R9 high bits ignored 128", 3'd2, 64'hFFFF_FFFF_FFFF_0000, 2'd0, 2'd0, 1'b1);

        // R5: same mask, 32-bit vs 64-bit granularity.
        run_op("R5 gran 32", 3'd1, 64'h0000_0000_0000_00A5, 2'd2, 2'd2, 1'b1);
        run_op("R5 gran 64", 3'd1, 64'h0000_0000_0000_00A5, 2'd3, 2'd2, 1'b1);

        // R2: idle cycle holds data and drops valid.
        begin
            logic [VB-1:0] held;
            run_op("R2 before idle", 3'd3, 64'h1234_5678_9ABC_DEF0, 2'd1, 2'd1, 1'b0);
            held = out_vec;
            in_valid = 1'b0; new_vec = rnd_vec(); old_vec = rnd_vec();
            @(posedge clk);
            @(negedge clk);
            check_bit("R2 idle valid", out_valid, 1'b0);
            check_vec("R2 idle hold", out_vec, held);
        end

        // R1: reset in mid-run clears the output.
        in_valid = 1'b1; rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_bit("R1 mid reset valid", out_valid, 1'b0);
        check_vec("R1 mid reset data", out_vec, '0);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule